// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Sequencer

This block is the host side of an enhanced parallel port. It turns one request from an internal register interface into a complete address or data transfer on a byte-wide bus. A request asks for either a write or a read of either the peripheral's address register or its data register. The block drives the active-low write qualifier, the two active-low strobes and the bus output enable. It listens to the peripheral's active-low wait line to stretch the transfer.

The strobe goes out first. The wait line is consulted only while the strobe is active. A low wait line holds the strobe, and a high wait line lets the transfer finish. If the peripheral never lets the wait line go high, a cycle counter ends the transfer and raises a timeout flag. That flag stays set until the next transfer is accepted. The peripheral's interrupt line is forwarded to the host unchanged.

Top module: `epp_cycle_engine`

## Requirements
- R1: For a write (`req_rd`=0), `n_write` is low and `bus_oe` is high from the clock after acceptance through the clock after the strobe is released. For a read (`req_rd`=1), `n_write` stays high and `bus_oe` stays low for the whole transfer.
- R2: On a write, `bus_out` carries the request byte with `bus_oe` high for at least one clock before either strobe goes low. The byte stays stable while the strobe is low.
- R3: `req_addr`=0 selects the data register and pulses only `n_dstb`. `req_addr`=1 selects the address register and pulses only `n_astb`. The two strobes are never low together.
- R4: `n_wait` passes through a two-flop synchronizer. While the synchronized level is low, the strobe is held low. The strobe is released only after `n_wait` has been seen high, or on a timeout.
- R5: If `n_wait` stays low, the strobe is released after exactly `TMO_LIMIT` clocks low and `tmo_flag` goes high. A read that times out returns 8'hFF on `rd_byte`.
- R6: On a read that ends normally, `rd_byte` takes the `bus_in` value present on the clock edge that releases the strobe. It holds that value until the next read ends.
- R7: `busy` is high from the clock after the start pulse until the strobe is released, and is high whenever a strobe is low.
- R8: A `start` pulse is ignored while `busy` is high and during the one idle clock that follows strobe release.
- R9: `tmo_flag` stays high after a timeout until the next transfer is accepted. That acceptance clears it.
- R10: `irq_out` follows `irq_in` with no inversion and no delay.
- R11: After reset, both strobes and `n_write` are high, `bus_oe`, `busy` and `tmo_flag` are low, and `rd_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a transfer |
| req_addr | input | 1 | 1 = address register, 0 = data register |
| req_rd | input | 1 | 1 = read, 0 = write |
| wr_byte | input | 8 | Byte to send on a write |
| rd_byte | output | 8 | Last byte read (8'hFF after a timed-out read) |
| busy | output | 1 | Transfer in progress |
| tmo_flag | output | 1 | Sticky timeout indication |
| bus_out | output | 8 | Byte driven toward the peripheral |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_in | input | 8 | Byte sampled from the peripheral bus |
| n_write | output | 1 | Active-low write qualifier |
| n_dstb | output | 1 | Active-low data strobe |
| n_astb | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Active-low wait from the peripheral |
| irq_in | input | 1 | Interrupt from the peripheral, active high |
| irq_out | output | 1 | Interrupt forwarded to the host |

## Verification
The bench builds the engine with `TMO_LIMIT` set to 12 instead of the default 1000. With that value, a stalled transfer hits the timeout path within a dozen strobe clocks, so the bench can count the exact strobe width on expiry. The same short limit still leaves room for stretched transfers of several wait clocks that end well before the timeout, so normal stretching and expiry are both reached in a short run.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_TERM   = 2'd3
    } epp_state_e;

    typedef struct packed {
        logic       is_addr;
        logic       is_read;
        logic [7:0] wdata;
    } epp_req_t;

    localparam logic [7:0] EPP_TMO_BYTE = 8'hFF;
    localparam int         EPP_CNT_W    = 16;

    function automatic logic strobe_low(input epp_state_e st, input logic want_addr,
                                        input logic is_addr);
        return (st == ST_STROBE) && (is_addr == want_addr);
    endfunction

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

    p_sync_delay_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_out) |-> $past(chain[0]));
endmodule

// File: rtl/epp_tmo_counter.sv
module epp_tmo_counter
    import epp_pkg::*;
#(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic expire
);
    localparam logic [EPP_CNT_W-1:0] LAST = EPP_CNT_W'(LIMIT - 1);

    logic [EPP_CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/epp_seq.sv
module epp_seq
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       req_addr,
    input  logic       req_rd,
    input  logic [7:0] wr_byte,
    input  logic [7:0] bus_in,
    input  logic       ready,
    input  logic       expire,
    output logic       tmo_run,
    output logic       tmo_clear,
    output logic [7:0] rd_byte,
    output logic       busy,
    output logic       tmo_flag,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       n_write,
    output logic       n_dstb,
    output logic       n_astb
);
    epp_state_e state;
    epp_req_t   req;
    logic       active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req      <= '0;
            rd_byte  <= '0;
            tmo_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    req      <= '{is_addr: req_addr, is_read: req_rd, wdata: wr_byte};
                    tmo_flag <= 1'b0;
                    state    <= ST_SETUP;
                end
                ST_SETUP: state <= ST_STROBE;
                ST_STROBE: begin
                    if (ready) begin
                        if (req.is_read) rd_byte <= bus_in;
                        state <= ST_TERM;
                    end else if (expire) begin
                        if (req.is_read) rd_byte <= EPP_TMO_BYTE;
                        tmo_flag <= 1'b1;
                        state    <= ST_TERM;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active    = (state != ST_IDLE);
    assign busy      = (state == ST_SETUP) || (state == ST_STROBE);
    assign tmo_run   = (state == ST_STROBE) && !ready;
    assign tmo_clear = (state != ST_STROBE);
    assign bus_out   = req.wdata;
    assign bus_oe    = active && !req.is_read;
    assign n_write   = !(active && !req.is_read);
    assign n_dstb    = !strobe_low(state, 1'b0, req.is_addr);
    assign n_astb    = !strobe_low(state, 1'b1, req.is_addr);

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        n_dstb || n_astb);
    p_busy_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (!n_dstb || !n_astb) |-> busy);
    p_bus_stable_r2: assert property (@(posedge clk) disable iff (rst)
        ((!n_dstb || !n_astb) && $past(state) == ST_STROBE) |-> $stable(bus_out));
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE && !ready && !expire) |=> state == ST_STROBE);
    p_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TERM) |=> (state == ST_IDLE && !busy));
    p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !(state == ST_IDLE && start)) |=> tmo_flag);
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int unsigned TMO_LIMIT   = 1000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       req_addr,
    input  logic       req_rd,
    input  logic [7:0] wr_byte,
    output logic [7:0] rd_byte,
    output logic       busy,
    output logic       tmo_flag,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    input  logic [7:0] bus_in,
    output logic       n_write,
    output logic       n_dstb,
    output logic       n_astb,
    input  logic       n_wait,
    input  logic       irq_in,
    output logic       irq_out
);
    logic ready, expire, tmo_run, tmo_clear;

    epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(n_wait), .sync_out(ready)
    );

    epp_tmo_counter #(.LIMIT(TMO_LIMIT)) u_tmo (
        .clk(clk), .rst(rst), .run(tmo_run), .clear(tmo_clear), .expire(expire)
    );

    epp_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_rd(req_rd),
        .wr_byte(wr_byte), .bus_in(bus_in), .ready(ready), .expire(expire),
        .tmo_run(tmo_run), .tmo_clear(tmo_clear), .rd_byte(rd_byte), .busy(busy),
        .tmo_flag(tmo_flag), .bus_out(bus_out), .bus_oe(bus_oe), .n_write(n_write),
        .n_dstb(n_dstb), .n_astb(n_astb)
    );

    assign irq_out = irq_in;

    p_irq_pass_r10: assert property (@(posedge clk) disable iff (rst)
        irq_out == irq_in);
endmodule

// File: tb/sim_epp_cycle_engine.sv
module sim_epp_cycle_engine;
    localparam int TMO = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, req_addr = 1'b0, req_rd = 1'b0;
    logic [7:0] wr_byte = 8'h00, bus_in = 8'h00;
    logic n_wait = 1'b1, irq_in = 1'b0;
    logic [7:0] rd_byte, bus_out;
    logic busy, tmo_flag, bus_oe, n_write, n_dstb, n_astb, irq_out;

    int tests = 0;
    int fails = 0;
    int strobe_cycles;

    always #10 clk = ~clk;

    epp_cycle_engine #(.TMO_LIMIT(TMO)) u0 (
        .clk(clk), .rst(rst), .start(start), .req_addr(req_addr), .req_rd(req_rd),
        .wr_byte(wr_byte), .rd_byte(rd_byte), .busy(busy), .tmo_flag(tmo_flag),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .n_write(n_write),
        .n_dstb(n_dstb), .n_astb(n_astb), .n_wait(n_wait), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One transfer with a peripheral model; returns at the negedge where busy is low.
    task automatic run_cycle(input bit is_addr, input bit is_rd, input logic [7:0] wb,
                             input int wait_clks, input logic [7:0] rb, input bit exp_tmo);
        bit first = 1'b1;
        bit prev_oe;
        logic [7:0] prev_out;
        int low = 0;
        n_wait = (wait_clks > 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        req_addr = is_addr; req_rd = is_rd; wr_byte = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        prev_oe = bus_oe; prev_out = bus_out;
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            if (!n_dstb || !n_astb) begin
                if (first && !is_rd)
                    chk(prev_oe && prev_out == wb, "R2 setup before strobe", prev_out, wb);
                first = 1'b0;
                low++;
                if (is_addr) chk(!n_astb && n_dstb, "R3 address strobe", {n_astb, n_dstb}, 2'b01);
                else         chk(!n_dstb && n_astb, "R3 data strobe", {n_astb, n_dstb}, 2'b10);
                chk(n_write == is_rd, "R1 n_write", n_write, is_rd);
                chk(bus_oe == !is_rd, "R1 bus_oe", bus_oe, !is_rd);
                if (!is_rd) chk(bus_out == wb, "R2 bus stable", bus_out, wb);
                if (low == wait_clks) begin
                    bus_in = rb;
                    n_wait = 1'b1;
                end
            end
            prev_oe = bus_oe; prev_out = bus_out;
            @(negedge clk);
        end
        strobe_cycles = low;
        chk(n_dstb && n_astb && !busy, "R7 strobe released with busy", {n_astb, n_dstb, busy}, 3'b110);
        chk(tmo_flag == exp_tmo, "R5 timeout flag", tmo_flag, exp_tmo);
        if (exp_tmo) chk(low == TMO, "R5 strobe width on timeout", low, TMO);
        else         chk(low >= wait_clks + 1 && low < TMO, "R4 stretched width", low, wait_clks + 1);
        if (is_rd) begin
            if (exp_tmo) chk(rd_byte == 8'hFF, "R5 timeout read byte", rd_byte, 8'hFF);
            else         chk(rd_byte == rb, "R6 read byte", rd_byte, rb);
        end
        n_wait = 1'b1;
    endtask

    task automatic test_reset();
        chk(n_dstb && n_astb && n_write, "R11 strobes high", {n_dstb, n_astb, n_write}, 3'b111);
        chk(!bus_oe && !busy && !tmo_flag, "R11 idle flags", {bus_oe, busy, tmo_flag}, 0);
        chk(rd_byte == 8'h00, "R11 rd_byte", rd_byte, 0);
    endtask

    task automatic test_writes();
        run_cycle(1'b0, 1'b0, 8'hA5, 0, 8'h00, 1'b0);
        run_cycle(1'b1, 1'b0, 8'h3C, 3, 8'h00, 1'b0);
    endtask

    task automatic test_reads();
        run_cycle(1'b0, 1'b1, 8'h00, 5, 8'h5A, 1'b0);
        bus_in = 8'h11;
        repeat (3) @(negedge clk);
        chk(rd_byte == 8'h5A, "R6 rd_byte holds", rd_byte, 8'h5A);
        run_cycle(1'b1, 1'b1, 8'h00, 1, 8'hC3, 1'b0);
    endtask

    task automatic test_timeout();
        run_cycle(1'b0, 1'b1, 8'h00, 1000, 8'h00, 1'b1);
        repeat (4) @(negedge clk);
        chk(tmo_flag == 1'b1, "R9 flag sticky", tmo_flag, 1);
        run_cycle(1'b1, 1'b0, 8'h77, 2, 8'h00, 1'b1 & 1'b0);
        chk(tmo_flag == 1'b0, "R9 cleared by next transfer", tmo_flag, 0);
        run_cycle(1'b1, 1'b0, 8'h81, 1000, 8'h00, 1'b1);
        chk(strobe_cycles == TMO, "R5 write timeout width", strobe_cycles, TMO);
    endtask

    task automatic test_ignored_start();
        int seen = 0;
        // start in the gap clock right after strobe release
        run_cycle(1'b0, 1'b0, 8'h42, 0, 8'h00, 1'b0);
        req_addr = 1'b1; req_rd = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (!n_dstb || !n_astb || busy) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R8 start in gap ignored", seen, 0);
        // start pulse while busy
        n_wait = 1'b0;
        req_addr = 1'b0; req_rd = 1'b0; wr_byte = 8'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        req_addr = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n_wait = 1'b1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (!n_astb) seen++;
            @(negedge clk);
        end
        chk(seen == 0 && !busy, "R8 start while busy ignored", seen, 0);
    endtask

    task automatic test_irq();
        irq_in = 1'b1; #1;
        chk(irq_out == 1'b1, "R10 irq high", irq_out, 1);
        irq_in = 1'b0; #1;
        chk(irq_out == 1'b0, "R10 irq low", irq_out, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_writes();
        test_reads();
        test_timeout();
        test_ignored_start();
        test_irq();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule